// File: doc/BRIEF.md
# Configurable 16x16 Registered Multiplier

This block multiplies two 16-bit operands and returns a 32-bit product. Everything runs on one clock. There are three load enables: one for each operand register and one for the product register. Each operand carries its own mode bit, so any mix of unsigned and two's-complement operands gives a correct product.

Before the product is stored, two optional adjustments can be applied:

- A round request adds a half-LSB of the upper half, so the upper half rounds upward.
- A format control chooses between the full 32-bit product and a one-bit left-shifted product for fractional signed work. In the shifted form, the sign is copied into the top bit of the lower half.

A pass-through control skips the product register, so the formatted product of the registered operands appears at the outputs in the same cycle. The upper output port carries either product half, chosen by a select input. The lower half always leaves on its own port. In a physical device the lower port shares its pins with the second operand input. Each port is modelled as a data bus plus a drive-enable output, and each drive enable is controlled by an active-low enable input.

Top module: `mul16_cfg`

## Requirements
- R1: Each operand register and its mode bit load from the inputs on a clock edge where that operand's load enable is high. They hold when the enable is low.
- R2: A mode bit of 0 treats its operand as unsigned and 1 treats it as two's complement. All four combinations give the exact product, taken modulo 2^32.
- R3: When `fmt_full` is 1, the stored word is the 32-bit product. Upper half is bits 31..16 and lower half is bits 15..0.
- R4: When `fmt_full` is 0, the word is formed from the (rounded) product s as follows. The upper half is s[30:15]. The lower half is {s[30], s[14:0]}, so bit 15 of the lower half equals bit 15 of the upper half.
- R5: When the registered round bit is 1, the block adds 2^15 to the product (with `fmt_full` = 1) or 2^14 (with `fmt_full` = 0) before formatting. The sum wraps modulo 2^32.
- R6: The round bit is registered from `rnd_in` on any edge where `a_ld` or `b_ld` is high, and it holds otherwise.
- R7: The product register loads the formatted product of the current registered operands on an edge where `p_ld` is high. It holds when `p_ld` is low, which gives one cycle of latency after the operand registers.
- R8: When `pass_thru` is 1, the outputs show the formatted product of the registered operands combinationally, using the present `fmt_full`.
- R9: When `up_sel_low` is 0, `up_out` carries the upper half. When it is 1, `up_out` carries the lower half. `lo_out` always carries the lower half.
- R10: `lo_drv` is the inverse of `lo_oe_n` and `up_drv` is the inverse of `up_oe_n`. The data outputs do not depend on these enables.
- R11: Two's-complement 0x8000 times 0x8000 with `fmt_full` = 0 and no rounding overflows to upper half 0x8000 and lower half 0x8000, and this is the expected result.
- R12: A synchronous active-high `rst` clears both operand registers, both mode bits, the round bit and the product register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| a_ld | input | 1 | Load enable for operand A and its mode bit |
| b_ld | input | 1 | Load enable for operand B and its mode bit |
| p_ld | input | 1 | Load enable for the 32-bit product register |
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| a_tc | input | 1 | Operand A mode: 1 = two's complement |
| b_tc | input | 1 | Operand B mode: 1 = two's complement |
| rnd_in | input | 1 | Round request, registered with the operands |
| fmt_full | input | 1 | 1 = full product, 0 = shifted fractional form |
| pass_thru | input | 1 | 1 = bypass the product register |
| up_sel_low | input | 1 | 1 = lower half on the upper port |
| lo_oe_n | input | 1 | Active-low drive enable, lower port |
| up_oe_n | input | 1 | Active-low drive enable, upper port |
| lo_out | output | 16 | Lower product half |
| lo_drv | output | 1 | Drive enable for `lo_out` |
| up_out | output | 16 | Upper port data |
| up_drv | output | 1 | Drive enable for `up_out` |

## Verification
The assertions assume two things about the inputs:

- The controls are two-valued.
- `fmt_full` does not change between a product load and the cycle in which the stored lower half is compared against the formatter output.

They also assume that a word captured while `pass_thru` is high is only compared once `pass_thru` is low again. The stimulus changes every input only on the falling clock edge. It spends its directed phase holding controls steady across each load. Its random phase draws all controls freely, but only makes claims that hold for any control sequence.

// File: rtl/mul16_pkg.sv
package mul16_pkg;
  localparam int OPW = 16;

  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_sel_e;

  typedef enum logic [2:0] {
    BD_ZERO,
    BD_POS1,
    BD_POS2,
    BD_NEG1,
    BD_NEG2
  } booth_dig_e;

  function automatic booth_dig_e booth_decode(input logic [2:0] grp);
    case (grp)
      3'b001, 3'b010: return BD_POS1;
      3'b011:         return BD_POS2;
      3'b100:         return BD_NEG2;
      3'b101, 3'b110: return BD_NEG1;
      default:        return BD_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/mul16_opreg.sv
module mul16_opreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         sgn_d,
  output logic [W-1:0] q,
  output logic         sgn_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      sgn_q <= 1'b0;
    end else if (ld) begin
      q     <= d;
      sgn_q <= sgn_d;
    end
  end
endmodule

// File: rtl/mul16_booth.sv
module mul16_booth import mul16_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  input  logic           mcand_sgn,
  input  logic           mplier_sgn,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;
  localparam int EW = ((W + 2) / 2) * 2;
  localparam int ND = EW / 2;

  logic signed [W:0]    a_ext;
  logic        [EW:0]   b_win;
  logic signed [PW-1:0] a_wide;
  logic signed [PW-1:0] pp [ND];

  assign a_ext  = {mcand_sgn & mcand[W-1], mcand};
  assign a_wide = PW'(a_ext);
  assign b_win  = {{(EW - W){mplier_sgn & mplier[W-1]}}, mplier, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_pp
    booth_dig_e           dig;
    logic signed [PW-1:0] mag;
    assign dig = booth_decode(b_win[2*i+2 -: 3]);
    always_comb begin
      case (dig)
        BD_POS1: mag = a_wide;
        BD_POS2: mag = a_wide <<< 1;
        BD_NEG1: mag = -a_wide;
        BD_NEG2: mag = -(a_wide <<< 1);
        default: mag = '0;
      endcase
    end
    assign pp[i] = mag <<< (2 * i);
  end

  always_comb begin
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < ND; i++) acc = acc + pp[i];
    prod = acc;
  end
endmodule

// File: rtl/mul16_fmt.sv
module mul16_fmt #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] raw,
  input  logic           rnd,
  input  logic           full,
  output logic [2*W-1:0] word
);
  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] round_bias(input logic en, input logic fl);
    logic [PW-1:0] b;
    b = '0;
    if (en) b[fl ? W-1 : W-2] = 1'b1;
    return b;
  endfunction

  function automatic logic [PW-1:0] shape(input logic [PW-1:0] s, input logic fl);
    if (fl) return s;
    return {s[PW-2:W-1], s[PW-2], s[W-2:0]};
  endfunction

  logic [PW-1:0] rounded;
  assign rounded = raw + round_bias(rnd, full);
  assign word    = shape(rounded, full);
endmodule

// File: rtl/mul16_outsel.sv
module mul16_outsel import mul16_pkg::*; #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] word,
  input  logic           up_sel_low,
  input  logic           lo_oe_n,
  input  logic           up_oe_n,
  output logic [W-1:0]   lo_out,
  output logic           lo_drv,
  output logic [W-1:0]   up_out,
  output logic           up_drv
);
  half_sel_e sel;
  assign sel    = half_sel_e'(up_sel_low);
  assign lo_out = word[W-1:0];
  assign up_out = (sel == HALF_LOWER) ? word[W-1:0] : word[2*W-1:W];
  assign lo_drv = ~lo_oe_n;
  assign up_drv = ~up_oe_n;
endmodule

// File: rtl/mul16_cfg.sv
module mul16_cfg import mul16_pkg::*; #(
  parameter int W = OPW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_ld,
  input  logic         b_ld,
  input  logic         p_ld,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         a_tc,
  input  logic         b_tc,
  input  logic         rnd_in,
  input  logic         fmt_full,
  input  logic         pass_thru,
  input  logic         up_sel_low,
  input  logic         lo_oe_n,
  input  logic         up_oe_n,
  output logic [W-1:0] lo_out,
  output logic         lo_drv,
  output logic [W-1:0] up_out,
  output logic         up_drv
);
  localparam int PW = 2 * W;

  logic [W-1:0]  a_q;
  logic [W-1:0]  b_q;
  logic          a_sgn_q;
  logic          b_sgn_q;
  logic          rnd_q;
  logic          rnd_cap;
  logic [PW-1:0] core_prod;
  logic [PW-1:0] fmt_word;
  logic [PW-1:0] prod_q;
  logic [PW-1:0] out_word;

  mul16_opreg #(.W(W)) u_opa (
    .clk(clk), .rst(rst), .ld(a_ld), .d(a_in), .sgn_d(a_tc),
    .q(a_q), .sgn_q(a_sgn_q)
  );

  mul16_opreg #(.W(W)) u_opb (
    .clk(clk), .rst(rst), .ld(b_ld), .d(b_in), .sgn_d(b_tc),
    .q(b_q), .sgn_q(b_sgn_q)
  );

  assign rnd_cap = a_ld | b_ld;

  always_ff @(posedge clk) begin
    if (rst)          rnd_q <= 1'b0;
    else if (rnd_cap) rnd_q <= rnd_in;
  end

  mul16_booth #(.W(W)) u_core (
    .mcand(a_q), .mplier(b_q), .mcand_sgn(a_sgn_q), .mplier_sgn(b_sgn_q),
    .prod(core_prod)
  );

  mul16_fmt #(.W(W)) u_fmt (
    .raw(core_prod), .rnd(rnd_q), .full(fmt_full), .word(fmt_word)
  );

  always_ff @(posedge clk) begin
    if (rst)       prod_q <= '0;
    else if (p_ld) prod_q <= fmt_word;
  end

  assign out_word = pass_thru ? fmt_word : prod_q;

  mul16_outsel #(.W(W)) u_out (
    .word(out_word), .up_sel_low(up_sel_low), .lo_oe_n(lo_oe_n), .up_oe_n(up_oe_n),
    .lo_out(lo_out), .lo_drv(lo_drv), .up_out(up_out), .up_drv(up_drv)
  );
endmodule

// File: rtl/mul16_cfg_chk.sv
module mul16_cfg_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           a_ld,
  input logic           b_ld,
  input logic           p_ld,
  input logic           rnd_in,
  input logic           fmt_full,
  input logic           pass_thru,
  input logic           up_sel_low,
  input logic [W-1:0]   lo_out,
  input logic [W-1:0]   up_out,
  input logic [W-1:0]   a_q,
  input logic [W-1:0]   b_q,
  input logic           a_sgn_q,
  input logic           b_sgn_q,
  input logic           rnd_q,
  input logic [2*W-1:0] core_prod,
  input logic [2*W-1:0] fmt_word
);
  localparam int PW = 2 * W;

  logic signed [W:0] ae;
  logic signed [W:0] be;
  logic [PW-1:0]     exact;
  assign ae    = {a_sgn_q & a_q[W-1], a_q};
  assign be    = {b_sgn_q & b_q[W-1], b_q};
  assign exact = PW'(ae) * PW'(be);

  assert_opa_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !a_ld |=> $stable(a_q));

  assert_booth_exact_R2: assert property (@(posedge clk) disable iff (rst)
    core_prod == exact);

  assert_sign_copy_R4: assert property (@(posedge clk) disable iff (rst)
    (pass_thru && !fmt_full && !up_sel_low) |-> (lo_out[W-1] == up_out[W-1]));

  assert_rnd_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (a_ld || b_ld) |=> (rnd_q == $past(rnd_in)));

  assert_rnd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(a_ld || b_ld) |=> $stable(rnd_q));

  assert_prod_load_R7: assert property (@(posedge clk) disable iff (rst)
    p_ld |=> (pass_thru || lo_out == $past(fmt_word[W-1:0])));

  assert_prod_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!p_ld && !pass_thru) |=> (pass_thru || $stable(lo_out)));

  assert_low_on_up_R9: assert property (@(posedge clk) disable iff (rst)
    up_sel_low |-> (up_out == lo_out));

  assert_reset_clear_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pass_thru || (lo_out == '0 && up_out == '0)));
endmodule

bind mul16_cfg mul16_cfg_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_ld(a_ld), .b_ld(b_ld), .p_ld(p_ld), .rnd_in(rnd_in),
  .fmt_full(fmt_full), .pass_thru(pass_thru), .up_sel_low(up_sel_low),
  .lo_out(lo_out), .up_out(up_out), .a_q(a_q), .b_q(b_q),
  .a_sgn_q(a_sgn_q), .b_sgn_q(b_sgn_q), .rnd_q(rnd_q),
  .core_prod(core_prod), .fmt_word(fmt_word)
);

// File: tb/sim_mul16_cfg.sv
`timescale 1ns/1ps
module sim_mul16_cfg;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_ld = 0, b_ld = 0, p_ld = 0;
  logic [15:0] a_in = 0, b_in = 0;
  logic a_tc = 0, b_tc = 0, rnd_in = 0, fmt_full = 1, pass_thru = 0;
  logic up_sel_low = 0, lo_oe_n = 1, up_oe_n = 1;
  logic [15:0] lo_out, up_out;
  logic lo_drv, up_drv;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mul16_cfg u0 (
    .clk(clk), .rst(rst), .a_ld(a_ld), .b_ld(b_ld), .p_ld(p_ld),
    .a_in(a_in), .b_in(b_in), .a_tc(a_tc), .b_tc(b_tc), .rnd_in(rnd_in),
    .fmt_full(fmt_full), .pass_thru(pass_thru), .up_sel_low(up_sel_low),
    .lo_oe_n(lo_oe_n), .up_oe_n(up_oe_n),
    .lo_out(lo_out), .lo_drv(lo_drv), .up_out(up_out), .up_drv(up_drv)
  );

  // behavioural model state
  logic [15:0] ma = 0, mb = 0;
  logic msa = 0, msb = 0, mr = 0;
  logic [31:0] mp = 0;

  function automatic logic [31:0] ref_word(input logic [15:0] a, input logic [15:0] b,
                                           input logic sa, input logic sb,
                                           input logic rnd, input logic full);
    longint av, bv, p;
    logic [31:0] s;
    av = sa ? longint'($signed(a)) : longint'(a);
    bv = sb ? longint'($signed(b)) : longint'(b);
    p  = av * bv;
    if (rnd) p = p + (full ? 64'sd32768 : 64'sd16384);
    s = p[31:0];
    if (full) return s;
    return {s[30:15], s[30], s[14:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ma <= 0; mb <= 0; msa <= 0; msb <= 0; mr <= 0; mp <= 0;
    end else begin
      if (a_ld) begin ma <= a_in; msa <= a_tc; end
      if (b_ld) begin mb <= b_in; msb <= b_tc; end
      if (a_ld || b_ld) mr <= rnd_in;
      if (p_ld) mp <= ref_word(ma, mb, msa, msb, mr, fmt_full);
    end
  end

  task automatic compare(input string tag);
    logic [31:0] w;
    logic [15:0] ue;
    w  = pass_thru ? ref_word(ma, mb, msa, msb, mr, fmt_full) : mp;
    ue = up_sel_low ? w[15:0] : w[31:16];
    checks++;
    if (lo_out !== w[15:0] || up_out !== ue || lo_drv !== ~lo_oe_n || up_drv !== ~up_oe_n) begin
      fails++;
      $display("FAIL %s lo=%h/%h up=%h/%h lo_drv=%b/%b up_drv=%b/%b", tag,
               lo_out, w[15:0], up_out, ue, lo_drv, ~lo_oe_n, up_drv, ~up_oe_n);
    end
  endtask

  // inputs are stable from the previous falling edge; compare after the next falling edge
  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string auto_tag();
    if (pass_thru) return "R8";
    if (up_sel_low) return "R9";
    if (!fmt_full) return "R4";
    if (mr) return "R5";
    return "R2";
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12: reset with every load enabled and data present
    a_in = 16'h1234; b_in = 16'h5678; a_ld = 1; b_ld = 1; p_ld = 1; rnd_in = 1;
    repeat (3) tick("R12");
    a_ld = 0; b_ld = 0; p_ld = 0; rnd_in = 0;
    @(negedge clk); rst = 0;
    tick("R12");

    // R10: drive enables follow inverted controls
    lo_oe_n = 0; up_oe_n = 1; tick("R10");
    lo_oe_n = 1; up_oe_n = 0; tick("R10");
    lo_oe_n = 0; up_oe_n = 0; tick("R10");

    // R1: load A only, then change A with load low, observed through bypass
    pass_thru = 1;
    a_in = 16'h0003; b_in = 16'h0005; a_ld = 1; b_ld = 1; tick("R1");
    a_ld = 0; b_ld = 0; a_in = 16'h7777; tick("R1");
    a_ld = 1; a_in = 16'h0009; tick("R1");
    a_ld = 0;

    // R2: mixed signedness on all-ones operands
    a_in = 16'hFFFF; b_in = 16'hFFFE; a_ld = 1; b_ld = 1;
    a_tc = 0; b_tc = 0; tick("R2");
    a_tc = 1; b_tc = 0; tick("R2");
    a_tc = 0; b_tc = 1; tick("R2");
    a_tc = 1; b_tc = 1; tick("R2");

    // R3 and R4: full versus shifted form, same operands
    a_in = 16'hC000; b_in = 16'h4000; fmt_full = 1; tick("R3");
    fmt_full = 0; tick("R4");

    // R5: rounding weight in both formats
    a_in = 16'h0100; b_in = 16'h0081; rnd_in = 1; fmt_full = 1; tick("R5");
    fmt_full = 0; tick("R5");
    a_ld = 0; b_ld = 0;

    // R6: round request without an operand load is not captured
    rnd_in = 0; a_ld = 1; tick("R6");
    a_ld = 0; rnd_in = 1; tick("R6");
    pass_thru = 0; p_ld = 1; fmt_full = 1; tick("R6");
    p_ld = 0; rnd_in = 0;

    // R7: one cycle latency, then hold while operands change
    a_in = 16'h0123; b_in = 16'h0456; a_ld = 1; b_ld = 1; tick("R7");
    a_ld = 0; b_ld = 0; p_ld = 1; tick("R7");
    p_ld = 0; a_in = 16'hFFFF; a_ld = 1; tick("R7");
    a_ld = 0; tick("R7");

    // R8: bypass shows the new operands at once
    pass_thru = 1; tick("R8");
    pass_thru = 0; tick("R8");

    // R9: half select on the upper port
    up_sel_low = 1; tick("R9");
    up_sel_low = 0; tick("R9");

    // R11: overflow case in the shifted signed form
    a_in = 16'h8000; b_in = 16'h8000; a_tc = 1; b_tc = 1; fmt_full = 0; rnd_in = 0;
    a_ld = 1; b_ld = 1; tick("R11");
    a_ld = 0; b_ld = 0; p_ld = 1; tick("R11");
    p_ld = 0; tick("R11");
    checks++;
    if (up_out !== 16'h8000 || lo_out !== 16'h8000) begin
      fails++;
      $display("FAIL R11 up=%h/8000 lo=%h/8000", up_out, lo_out);
    end

    // random phase over all controls
    for (int n = 0; n < 3000; n++) begin
      a_in = 16'($urandom); b_in = 16'($urandom);
      a_tc = 1'($urandom); b_tc = 1'($urandom);
      a_ld = ($urandom % 4) != 0; b_ld = ($urandom % 4) != 0; p_ld = ($urandom % 4) != 0;
      rnd_in = 1'($urandom); fmt_full = 1'($urandom); pass_thru = ($urandom % 4) == 0;
      up_sel_low = 1'($urandom); lo_oe_n = 1'($urandom); up_oe_n = 1'($urandom);
      if (n % 8 == 0) begin a_in = 16'h8000; b_in = 16'h8000; end
      tick(auto_tag());
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule